// File: doc/BRIEF.md
# Fractional-Rate Master Counter

This block keeps a free-running 64-bit count whose average advance rate is a fixed fraction of its input clock. Each clock adds a programmable numerator to a fractional accumulator. When the accumulator reaches the programmable denominator, the count steps by one and the denominator is subtracted. Software picks the ratio that matches the input clock frequency so that the count runs at 6.144 MHz whatever that frequency is.

Some standard ratios, all of which fit the 12-bit fields, are:

| Input clock | Ratio |
|---|---|
| 12 MHz | 64/125 |
| 13 MHz | 768/1625 |
| 19.2 MHz | 8/25 |
| 20 MHz | 192/625 |
| 26 MHz | 384/1625 |
| 27 MHz | 256/1125 |
| 38.4 MHz | 4/25 |
| Emulated slow reference (system clock / 610) | 75/244 |

A simple single-cycle register port gives access to both ratio values and to the count. The count is read as two 32-bit halves. Reading the low half captures the high half, so software always sees a consistent 64-bit pair. The full count is also driven on a port for local timer logic.

Top module: `mctr_top`

## Requirements
- R1: While rst_ni is low, count_o equals COUNT_RST. After reset, the numerator ratio field reads NUM_RST and the denominator ratio field reads DEN_RST.
- R2: The register map is as follows; a write to a ratio register loads wdata_i[11:0] into that register's ratio field (bits 11:0).

  | Offset | Register |
  |---|---|
  | 0x00 | Count low half |
  | 0x04 | Count high half |
  | 0x10 | Numerator |
  | 0x14 | Denominator |

- R3: Bits 31:12 of the numerator register always read NUM_HI_RST, and those of the denominator register always read DEN_HI_RST. A write never changes them.
- R4: With 0 < num < den and the accumulator starting at zero, N clocks later the count has advanced by exactly floor(N*num/den). It never advances by more than one per clock.
- R5: A write to either ratio register clears the accumulator and holds the count on that clock edge. The new ratio applies from the next edge.
- R6: A denominator of zero halts the block: the count holds and the accumulator stays at zero.
- R7: When den is nonzero and num >= den, the count advances by one on every clock.
- R8: A read of offset 0x00 returns count bits 31:0 and captures bits 63:32. A later read of 0x04 returns the captured value, even if the count has since carried into the high half.
- R9: Writes to offsets 0x00 and 0x04 have no effect on the count. A read of an unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the cycle of the request |
| count_o | output | 2*DATA_W | Current count |

## Verification
The bench measures the count advance over long windows for several standard ratios and for the fallback ratio, starting from a cleared accumulator. A wrong carry compare or a missing subtract shows up as an off-by-one or a runaway count. It reprograms the ratio while the accumulator holds a known nonzero remainder, so a design that fails to clear the accumulator ends one count high. It also starts the count just below a 32-bit carry and reads the low half before the carry and the high half after it; a design without the capture returns a torn value. Further tests cover a zero denominator, a numerator at or above the denominator, write-protected upper fields and writes to the count offsets, each of which would show drift or a changed field if handled wrongly.

// File: rtl/mctr_pkg.sv
package mctr_pkg;
  localparam int ADDR_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  localparam addr_t OFF_CNT_LO = 8'h00;
  localparam addr_t OFF_CNT_HI = 8'h04;
  localparam addr_t OFF_NUM    = 8'h10;
  localparam addr_t OFF_DEN    = 8'h14;
endpackage

// File: rtl/mctr_regs.sv
module mctr_regs
  import mctr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RATIO_W = 12,
  parameter logic [RATIO_W-1:0] NUM_RST = 12'd4,
  parameter logic [RATIO_W-1:0] DEN_RST = 12'd25,
  parameter logic [DATA_W-RATIO_W-1:0] NUM_HI_RST = '0,
  parameter logic [DATA_W-RATIO_W-1:0] DEN_HI_RST = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  addr_t              addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  cnt_lo_i,
  input  logic [DATA_W-1:0]  cnt_hi_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [RATIO_W-1:0] num_o,
  output logic [RATIO_W-1:0] den_o,
  output logic               ratio_wr_o
);
  logic wr_num, wr_den;
  logic unused_hi;

  assign wr_num     = req_i && we_i && (addr_i == OFF_NUM);
  assign wr_den     = req_i && we_i && (addr_i == OFF_DEN);
  assign ratio_wr_o = wr_num || wr_den;
  assign unused_hi  = ^wdata_i[DATA_W-1:RATIO_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      num_o <= NUM_RST;
      den_o <= DEN_RST;
    end else begin
      if (wr_num) num_o <= wdata_i[RATIO_W-1:0];
      if (wr_den) den_o <= wdata_i[RATIO_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      unique case (addr_i)
        OFF_CNT_LO: rdata_o = cnt_lo_i;
        OFF_CNT_HI: rdata_o = cnt_hi_i;
        OFF_NUM:    rdata_o = {NUM_HI_RST, num_o};
        OFF_DEN:    rdata_o = {DEN_HI_RST, den_o};
        default:    rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mctr_frac.sv
module mctr_frac #(
  parameter int RATIO_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] num_i,
  input  logic [RATIO_W-1:0] den_i,
  input  logic               clr_i,
  output logic               step_o,
  output logic [RATIO_W-1:0] acc_o
);
  localparam int SUM_W = RATIO_W + 1;

  logic [RATIO_W-1:0] acc_q, acc_d;
  logic [SUM_W-1:0]   sum, rem;

  assign sum = {1'b0, acc_q} + {1'b0, num_i};
  assign rem = sum - {1'b0, den_i};

  always_comb begin
    step_o = 1'b0;
    acc_d  = '0;
    if (clr_i || den_i == '0) begin
      step_o = 1'b0;
      acc_d  = '0;
    end else if (num_i >= den_i) begin
      // ratio at or above one saturates to one step per clock
      step_o = 1'b1;
      acc_d  = '0;
    end else if (sum >= {1'b0, den_i}) begin
      step_o = 1'b1;
      acc_d  = rem[RATIO_W-1:0];
    end else begin
      acc_d  = sum[RATIO_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/mctr_count.sv
module mctr_count #(
  parameter int DATA_W = 32,
  parameter logic [2*DATA_W-1:0] COUNT_RST = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic                snap_i,
  output logic [2*DATA_W-1:0] count_o,
  output logic [DATA_W-1:0]   hi_snap_o
);
  localparam int COUNT_W = 2 * DATA_W;

  logic [COUNT_W-1:0] count_q;
  logic [DATA_W-1:0]  hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= COUNT_RST;
      hi_q    <= COUNT_RST[COUNT_W-1:DATA_W];
    end else begin
      if (step_i) count_q <= count_q + COUNT_W'(1);
      if (snap_i) hi_q    <= count_q[COUNT_W-1:DATA_W];
    end
  end

  assign count_o   = count_q;
  assign hi_snap_o = hi_q;
endmodule

// File: rtl/mctr_top.sv
module mctr_top
  import mctr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RATIO_W = 12,
  parameter logic [RATIO_W-1:0] NUM_RST = 12'd4,
  parameter logic [RATIO_W-1:0] DEN_RST = 12'd25,
  parameter logic [DATA_W-RATIO_W-1:0] NUM_HI_RST = '0,
  parameter logic [DATA_W-RATIO_W-1:0] DEN_HI_RST = '0,
  parameter logic [2*DATA_W-1:0] COUNT_RST = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [2*DATA_W-1:0] count_o
);
  logic [RATIO_W-1:0] num_w, den_w, acc_w;
  logic               ratio_wr_w, step_w, snap_w;
  logic [DATA_W-1:0]  hi_snap_w;

  assign snap_w = req_i && !we_i && (addr_i == OFF_CNT_LO);

  mctr_regs #(
    .DATA_W(DATA_W), .RATIO_W(RATIO_W),
    .NUM_RST(NUM_RST), .DEN_RST(DEN_RST),
    .NUM_HI_RST(NUM_HI_RST), .DEN_HI_RST(DEN_HI_RST)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .cnt_lo_i(count_o[DATA_W-1:0]), .cnt_hi_i(hi_snap_w),
    .rdata_o(rdata_o), .num_o(num_w), .den_o(den_w), .ratio_wr_o(ratio_wr_w)
  );

  mctr_frac #(.RATIO_W(RATIO_W)) u_frac (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .num_i(num_w), .den_i(den_w), .clr_i(ratio_wr_w),
    .step_o(step_w), .acc_o(acc_w)
  );

  mctr_count #(.DATA_W(DATA_W), .COUNT_RST(COUNT_RST)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .step_i(step_w), .snap_i(snap_w),
    .count_o(count_o), .hi_snap_o(hi_snap_w)
  );
endmodule

// File: rtl/mctr_checker.sv
module mctr_checker #(
  parameter int DATA_W = 32,
  parameter int RATIO_W = 12
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2*DATA_W-1:0] count_i,
  input logic [RATIO_W-1:0]  num_i,
  input logic [RATIO_W-1:0]  den_i,
  input logic [RATIO_W-1:0]  acc_i,
  input logic                ratio_wr_i,
  input logic                snap_i,
  input logic [DATA_W-1:0]   hi_snap_i
);
  localparam int COUNT_W = 2 * DATA_W;

  AST_STEP_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (count_i == $past(count_i)) || (count_i == $past(count_i) + COUNT_W'(1))); // R4
  AST_ACC_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_i != '0) |-> (acc_i < den_i)); // R4
  AST_WR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ratio_wr_i |=> ($stable(count_i) && acc_i == '0)); // R5
  AST_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_i == '0) |=> ($stable(count_i) && acc_i == '0)); // R6
  AST_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_i != '0 && num_i >= den_i && !ratio_wr_i) |=> (count_i == $past(count_i) + COUNT_W'(1))); // R7
  AST_SNAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_i |=> (hi_snap_i == $past(count_i[COUNT_W-1:DATA_W]))); // R8
endmodule

bind mctr_top mctr_checker #(.DATA_W(DATA_W), .RATIO_W(RATIO_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .count_i(count_o),
  .num_i(num_w), .den_i(den_w), .acc_i(acc_w),
  .ratio_wr_i(ratio_wr_w), .snap_i(snap_w), .hi_snap_i(hi_snap_w)
);

// File: tb/tb_mctr_top.sv
module tb_mctr_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam logic [63:0] CRST = 64'h0000_0001_FFFF_FF00;
  localparam logic [19:0] NHI = 20'hA5A5A;
  localparam logic [19:0] DHI = 20'h3C3C3;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] count;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mctr_top #(.NUM_HI_RST(NHI), .DEN_HI_RST(DHI), .COUNT_RST(CRST)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .count_o(count)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // tasks start and end just after a negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    req = 1; we = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 0;
  endtask

  task automatic set_ratio(input logic [11:0] n, input logic [11:0] d);
    wr(8'h10, {20'hFFFFF, n});
    wr(8'h14, {20'h12345, d});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 count in reset", count, CRST);
    @(negedge clk);
    rst_n = 1;
    rd(8'h10, v); chk("R1 num reset", 64'(v), 64'({NHI, 12'd4}));
    rd(8'h14, v); chk("R1 den reset", 64'(v), 64'({DHI, 12'd25}));
    rd(8'h08, v); chk("R9 unmapped read", 64'(v), 64'd0);
  endtask

  task automatic t_snapshot();
    logic [31:0] lo, hi;
    logic [31:0] exp_hi;
    set_ratio(12'd1, 12'd1);
    while (count[31:0] < 32'hFFFF_FFF8) @(negedge clk);
    exp_hi = count[63:32];
    rd(8'h00, lo);
    chk("R8 low half", 64'(lo), 64'hFFFF_FFF8);
    repeat (20) @(negedge clk);
    chk("R8 count carried", 64'(count[63:32]), 64'd2);
    rd(8'h04, hi);
    chk("R8 captured high", 64'(hi), 64'(exp_hi));
    rd(8'h00, lo);
    rd(8'h04, hi);
    chk("R8 fresh high", 64'(hi), 64'd2);
  endtask

  task automatic t_fields();
    logic [31:0] v;
    wr(8'h10, 32'hFFFF_F040);
    rd(8'h10, v); chk("R2 R3 num field write", 64'(v), 64'({NHI, 12'h040}));
    wr(8'h14, 32'h0000_0ABC);
    rd(8'h14, v); chk("R2 R3 den field write", 64'(v), 64'({DHI, 12'hABC}));
  endtask

  task automatic t_rate(input logic [11:0] n, input logic [11:0] d, input int cyc, input string tag);
    logic [63:0] c0;
    set_ratio(n, d);
    c0 = count;
    repeat (cyc) @(negedge clk);
    chk(tag, count - c0, (64'(cyc) * 64'(n)) / 64'(d));
  endtask

  task automatic t_reprogram();
    logic [63:0] c0;
    set_ratio(12'd75, 12'd244);
    repeat (100) @(negedge clk);
    c0 = count;
    wr(8'h14, 32'd244);
    chk("R5 count held on write edge", count, c0);
    repeat (100) @(negedge clk);
    chk("R5 accumulator cleared", count - c0, 64'd30);
  endtask

  task automatic t_halt();
    logic [63:0] c0;
    set_ratio(12'd4, 12'd0);
    c0 = count;
    repeat (100) @(negedge clk);
    chk("R6 zero den halts", count, c0);
    wr(8'h14, 32'd25);
    c0 = count;
    repeat (50) @(negedge clk);
    chk("R6 restart after halt", count - c0, 64'd8);
  endtask

  task automatic t_fast();
    logic [63:0] c0;
    set_ratio(12'd300, 12'd7);
    c0 = count;
    repeat (50) @(negedge clk);
    chk("R7 num above den", count - c0, 64'd50);
    c0 = count;
    wr(8'h00, 32'h0);
    wr(8'h04, 32'h0);
    chk("R9 count writes ignored", count - c0, 64'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_snapshot();
    t_fields();
    t_rate(12'd64, 12'd125, 1000, "R4 rate 64/125");
    t_rate(12'd768, 12'd1625, 3250, "R4 rate 768/1625");
    t_rate(12'd192, 12'd625, 1250, "R4 rate 192/625");
    t_rate(12'd256, 12'd1125, 2000, "R4 rate 256/1125");
    t_rate(12'd75, 12'd244, 1000, "R4 rate 75/244 fallback");
    t_rate(12'd8, 12'd25, 333, "R4 rate 8/25 partial window");
    t_reprogram();
    t_halt();
    t_fast();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule